// File: doc/BRIEF.md
# Synthesiser Control Slave on a Two-Wire Serial Bus

This block is the serial control front end of a frequency-synthesiser chip. It oversamples the bus clock and data lines with a fast system clock and pulls the data line low through an open-drain enable. A 2-bit select input picks one of four device addresses, so up to four synthesisers can share one bus. Write transfers load a 15-bit divide ratio, a control byte and an output-port byte. Read transfers return a status byte that arrives on plain input pins.

In a write transfer, each data byte is routed by its own most significant bit rather than by a sub-address. A leading 0 opens a frequency pair. A leading 1 opens a control pair. The master may keep sending pairs until it issues a stop, which allows smooth tuning sweeps. A byte that is cut short by a stop or a repeated start is discarded. The divide word reaches the output as a single update, at the moment its second byte completes.

Top module: `synth_i2c_slave`

## Requirements
- R1: After reset, the divide ratio, the control byte, the port byte and both pump flags read zero, and the data line is not driven.
- R2: The slave acknowledges an address byte only when the top seven bits equal binary 11000 followed by the 2-bit select input. It acknowledges by holding the data line low for the ninth clock. For any other address it stays silent, and the transfer changes no register.
- R3: In a write transfer, the slave acknowledges every data byte. Any number of bytes may follow one address byte, up to the stop.
- R4: A write byte with bit 7 equal to 0 opens a frequency pair. Its bits 6..0 become divide bits 14..8, and the next byte supplies divide bits 7..0. The divide output changes only when that second byte completes.
- R5: A write byte with bit 7 equal to 1 is stored whole as the control byte, and the byte after it is stored as the port byte. The output pump_high_o follows control bit 2, and pump_off_o follows control bit 4.
- R6: Once a pair completes, the next byte is classified again by its bit 7. Each newly acknowledged write address restarts classification, so an unfinished pair from an earlier transfer is dropped.
- R7: A byte interrupted by a stop or a repeated start changes no register. A repeated start returns the slave to address reception.
- R8: When the address bit 0 is 1, the slave shifts out the status input, MSB first, changing data only while the clock is low. After each byte it sends a fresh status byte if the master acknowledged. After a not-acknowledge it releases the line and stays silent until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Chooses one of four device addresses |
| status_i | input | 8 | Byte returned by read transfers |
| div_ratio_o | output | 15 | Programmable divider ratio |
| ctrl_o | output | 8 | Control byte |
| port_o | output | 8 | Output-port byte |
| pump_high_o | output | 1 | High charge-pump current selected |
| pump_off_o | output | 1 | Charge-pump output disabled |

## Verification
Write traffic covers several cases: frequency pairs, control pairs, four bytes under a single address, and a frequency byte left unpaired across a stop. Together these separate steering by the leading bit from steering by position, and show that pair classification restarts at each new address. The bench also sends an address under the wrong select value and then the right one, and it aborts bytes with both a stop and a repeated start. These cases show that only matched, complete bytes are committed. A read with a master acknowledge followed by a not-acknowledge shows that the status is sampled again for each byte and that the line is released afterwards.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } link_st_e;

    typedef enum logic [1:0] {
        PH_ANY, PH_FREQ_LO, PH_CTRL_LO
    } pair_ph_e;

    typedef struct packed {
        link_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;
        logic              rw;
        logic              oe;
        logic              mack;
        logic              stb;
        logic [BYTE_W-1:0] sbyte;
        logic              clr;
    } link_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] scl_sh_q;
    logic [LAST:0] sda_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
        end else begin
            scl_sh_q <= {scl_sh_q[LAST-1:0], scl_i};
            sda_sh_q <= {sda_sh_q[LAST-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sh_q[LAST-1];
    assign scl_old = scl_sh_q[LAST];
    assign sda_now = sda_sh_q[LAST-1];
    assign sda_old = sda_sh_q[LAST];

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/synth_i2c_link.sv
module synth_i2c_link
    import synth_i2c_pkg::*;
#(
    parameter logic [4:0] ADDR_BASE = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [1:0]        sel_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              oe_o,
    output logic              stb_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              clr_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    link_t cur_q, cur_d;

    always_comb begin
        cur_d     = cur_q;
        cur_d.stb = 1'b0;
        cur_d.clr = 1'b0;
        if (start_evt) begin
            cur_d.st  = ST_ADDR;
            cur_d.cnt = '0;
            cur_d.oe  = 1'b0;
        end else if (stop_evt) begin
            cur_d.st = ST_IDLE;
            cur_d.oe = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && cur_q.cnt < FULL) begin
                        cur_d.sr  = {cur_q.sr[BYTE_W-2:0], sda};
                        cur_d.cnt = cur_q.cnt + 1'b1;
                        if (cur_q.st == ST_WDATA && cur_q.cnt == LAST_BIT) begin
                            cur_d.stb   = 1'b1;
                            cur_d.sbyte = {cur_q.sr[BYTE_W-2:0], sda};
                        end
                    end
                    if (scl_fall && cur_q.cnt == FULL) begin
                        if (cur_q.st == ST_WDATA) begin
                            cur_d.st = ST_WACK;
                            cur_d.oe = 1'b1;
                        end else if (cur_q.sr[BYTE_W-1:1] == {ADDR_BASE, sel_i}) begin
                            cur_d.st  = ST_AACK;
                            cur_d.rw  = cur_q.sr[0];
                            cur_d.oe  = 1'b1;
                            cur_d.clr = ~cur_q.sr[0];
                        end else begin
                            cur_d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (scl_fall) begin
                        cur_d.cnt = '0;
                        if (cur_q.st == ST_AACK && cur_q.rw) begin
                            cur_d.st = ST_RDATA;
                            cur_d.sr = status_i;
                            cur_d.oe = ~status_i[BYTE_W-1];
                        end else begin
                            cur_d.st = ST_WDATA;
                            cur_d.oe = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && cur_q.cnt < FULL) begin
                        cur_d.cnt = cur_q.cnt + 1'b1;
                    end
                    if (scl_fall) begin
                        if (cur_q.cnt == FULL) begin
                            cur_d.st = ST_RACK;
                            cur_d.oe = 1'b0;
                        end else begin
                            cur_d.sr = {cur_q.sr[BYTE_W-2:0], 1'b0};
                            cur_d.oe = ~cur_q.sr[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        cur_d.mack = ~sda;
                    end
                    if (scl_fall) begin
                        if (cur_q.mack) begin
                            cur_d.st  = ST_RDATA;
                            cur_d.cnt = '0;
                            cur_d.sr  = status_i;
                            cur_d.oe  = ~status_i[BYTE_W-1];
                        end else begin
                            cur_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, default: '0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign oe_o   = cur_q.oe;
    assign stb_o  = cur_q.stb;
    assign byte_o = cur_q.sbyte;
    assign clr_o  = cur_q.clr;
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_i2c_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              clr_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] port_o
);
    localparam int HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        pair_ph_e          ph;
        logic [HI_W-1:0]   hi;
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] port;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (clr_i) begin
            bank_d.ph = PH_ANY;
        end else if (stb_i) begin
            unique case (bank_q.ph)
                PH_FREQ_LO: begin
                    bank_d.div = {bank_q.hi, byte_i};
                    bank_d.ph  = PH_ANY;
                end
                PH_CTRL_LO: begin
                    bank_d.port = byte_i;
                    bank_d.ph   = PH_ANY;
                end
                default: begin
                    if (byte_i[BYTE_W-1]) begin
                        bank_d.ctrl = byte_i;
                        bank_d.ph   = PH_CTRL_LO;
                    end else begin
                        bank_d.hi = byte_i[HI_W-1:0];
                        bank_d.ph = PH_FREQ_LO;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '{ph: PH_ANY, default: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign div_o  = bank_q.div;
    assign ctrl_o = bank_q.ctrl;
    assign port_o = bank_q.port;
endmodule

// File: rtl/synth_i2c_slave.sv
module synth_i2c_slave
    import synth_i2c_pkg::*;
#(
    parameter int         DIV_W     = 15,
    parameter int         SYNC_LEN  = 2,
    parameter logic [4:0] ADDR_BASE = 5'b11000,
    parameter int         PUMP_BIT  = 2,
    parameter int         OFF_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic [DIV_W-1:0]  div_ratio_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] port_o,
    output logic              pump_high_o,
    output logic              pump_off_o
);
    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic byte_stb, pair_clr;
    logic [BYTE_W-1:0] rx_byte;

    i2c_line_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_evt), .stop_o(stop_evt)
    );

    synth_i2c_link #(.ADDR_BASE(ADDR_BASE)) u_link (
        .clk(clk), .rst_n(rst_n), .sda(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .sel_i(addr_sel_i), .status_i(status_i), .oe_o(sda_oe_o),
        .stb_o(byte_stb), .byte_o(rx_byte), .clr_o(pair_clr)
    );

    synth_reg_bank #(.DIV_W(DIV_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .stb_i(byte_stb), .byte_i(rx_byte),
        .clr_i(pair_clr), .div_o(div_ratio_o), .ctrl_o(ctrl_o), .port_o(port_o)
    );

    assign pump_high_o = ctrl_o[PUMP_BIT];
    assign pump_off_o  = ctrl_o[OFF_BIT];
endmodule

// File: rtl/synth_i2c_slave_chk.sv
module synth_i2c_slave_chk #(
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe_o,
    input logic [DIV_W-1:0] div_ratio_o,
    input logic [7:0]       ctrl_o,
    input logic [7:0]       port_o,
    input logic             wr_stb,
    input logic             start_evt,
    input logic             stop_evt,
    input logic             fall_evt
);
    AST_DIV_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(div_ratio_o)); // R4
    AST_CTRL_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> ($stable(ctrl_o) && $stable(port_o))); // R5
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe_o); // R7
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe_o); // R8
    AST_DRIVE_MOVES_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_evt || start_evt || stop_evt) |=> $stable(sda_oe_o)); // R8
endmodule

bind synth_i2c_slave synth_i2c_slave_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .div_ratio_o(div_ratio_o),
    .ctrl_o(ctrl_o), .port_o(port_o), .wr_stb(byte_stb), .start_evt(start_evt),
    .stop_evt(stop_evt), .fall_evt(scl_fall)
);

// File: tb/synth_i2c_slave_test.sv
`timescale 1ns/1ps
module synth_i2c_slave_test;
    localparam int HP = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] sel = 2'b01;
    logic [7:0] status = 8'h00;
    logic sda_oe;
    logic [14:0] div;
    logic [7:0] ctrl, port;
    logic pump_hi, pump_off;
    wire sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    synth_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(sel), .status_i(status),
        .div_ratio_o(div), .ctrl_o(ctrl), .port_o(port),
        .pump_high_o(pump_hi), .pump_off_o(pump_off)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit settled = 1'b0;

    // behavioural reference state
    logic [14:0] exp_div = '0;
    logic [7:0] exp_ctrl = '0, exp_port = '0;
    logic [6:0] m_hi = '0;
    int m_ph = 0;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock comparison of register outputs against the model (R4 R5 R6 R7)
    always @(negedge clk) begin
        if (rst_n && settled && !done) begin
            tests++;
            if (div !== exp_div || ctrl !== exp_ctrl || port !== exp_port ||
                pump_hi !== exp_ctrl[2] || pump_off !== exp_ctrl[4]) begin
                fails++;
                $display("FAIL R4/R5 regs: actual %h/%h/%h expected %h/%h/%h",
                         div, ctrl, port, exp_div, exp_ctrl, exp_port);
            end
        end
    end

    function automatic void model_byte(input logic [7:0] b);
        case (m_ph)
            1: begin exp_div = {m_hi, b}; m_ph = 0; end
            2: begin exp_port = b; m_ph = 0; end
            default: begin
                if (b[7]) begin exp_ctrl = b; m_ph = 2; end
                else begin m_hi = b[6:0]; m_ph = 1; end
            end
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; idle(HP);
        sda_m = 1'b0; idle(HP);
        scl_m = 1'b0; idle(HP/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(HP/2);
        scl_m = 1'b1; idle(HP);
        sda_m = 1'b1; idle(HP);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; idle(HP/2);
        scl_m = 1'b1; idle(HP);
        scl_m = 1'b0; idle(HP/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_line);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; idle(HP/2);
        scl_m = 1'b1; idle(HP/2);
        ack_line = sda_line;
        idle(HP/2);
        scl_m = 1'b0; idle(HP/2);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            idle(HP/2); scl_m = 1'b1; idle(HP/2);
            b = {b[6:0], sda_line};
            idle(HP/2); scl_m = 1'b0; idle(HP/2);
        end
    endtask

    task automatic master_ack(input logic give);
        sda_m = ~give; idle(HP/2);
        scl_m = 1'b1; idle(HP);
        scl_m = 1'b0; idle(1);
        sda_m = 1'b1; idle(HP/2);
    endtask

    task automatic addr_phase(input logic [7:0] a, output logic hit);
        logic ln;
        hit = (a[7:1] == {5'b11000, sel});
        send_byte(a, ln);
        check("R2 address ack", int'(ln), hit ? 0 : 1);
        if (hit && !a[0]) m_ph = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic hit);
        logic ln;
        settled = 1'b0;
        send_byte(b, ln);
        if (hit) model_byte(b);
        check("R3 data ack", int'(ln), hit ? 0 : 1);
        settled = 1'b1;
    endtask

    task automatic wr_frame(input logic [7:0] a, input logic [7:0] d0, d1, d2, d3, input int n);
        logic hit;
        bus_start();
        addr_phase(a, hit);
        if (n > 0) wr_byte(d0, hit);
        if (n > 1) wr_byte(d1, hit);
        if (n > 2) wr_byte(d2, hit);
        if (n > 3) wr_byte(d3, hit);
        bus_stop();
    endtask

    initial begin
        logic hit;
        logic [7:0] rd;
        idle(5);
        // R1 reset state
        check("R1 div", int'(div), 0);
        check("R1 ctrl/port", int'({ctrl, port}), 0);
        check("R1 sda released", int'(sda_oe), 0);
        rst_n = 1'b1;
        idle(5);
        settled = 1'b1;

        // R4 frequency pair
        wr_frame(8'hC2, 8'h12, 8'h34, 0, 0, 2);
        check("R4 divide word", int'(div), 15'h1234);
        // R5 control pair, pump bits 2 and 4 set
        wr_frame(8'hC2, 8'hD4, 8'hA5, 0, 0, 2);
        check("R5 pump high bit2", int'(pump_hi), 1);
        check("R5 pump off bit4", int'(pump_off), 1);
        check("R5 port byte", int'(port), 8'hA5);
        // R3 R6 four bytes under one address, reclassified per pair
        wr_frame(8'hC2, 8'h7F, 8'hFF, 8'h80, 8'h0F, 4);
        check("R6 divide after two pairs", int'(div), 15'h7FFF);
        check("R6 control after two pairs", int'(ctrl), 8'h80);
        // R2 wrong select: silent, no effect
        wr_frame(8'hC4, 8'h01, 8'h02, 0, 0, 2);
        check("R2 ignored address", int'(div), 15'h7FFF);
        // R2 select changed to 2'b10: same address now answers
        sel = 2'b10;
        wr_frame(8'hC4, 8'h01, 8'h02, 0, 0, 2);
        check("R2 matched after select", int'(div), 15'h0102);
        // R6 unfinished pair dropped at new address
        wr_frame(8'hC4, 8'h05, 0, 0, 0, 1);
        wr_frame(8'hC4, 8'h90, 8'h11, 0, 0, 2);
        check("R6 pair restart ctrl", int'(ctrl), 8'h90);
        check("R6 divide untouched", int'(div), 15'h0102);
        // R7 partial byte ended by stop
        bus_start();
        addr_phase(8'hC4, hit);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check("R7 stop mid byte", int'(div), 15'h0102);
        // R7 partial byte ended by repeated start, then fresh pair
        bus_start();
        addr_phase(8'hC4, hit);
        wr_byte(8'h33, hit);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_start();
        addr_phase(8'hC4, hit);
        wr_byte(8'h44, hit);
        wr_byte(8'h55, hit);
        bus_stop();
        check("R7 repeated start recovery", int'(div), 15'h4455);
        // R8 read with master ack then nack
        status = 8'hA6;
        bus_start();
        addr_phase(8'hC5, hit);
        recv_byte(rd);
        check("R8 first status", int'(rd), 8'hA6);
        status = 8'h3C;
        master_ack(1'b1);
        recv_byte(rd);
        check("R8 second status", int'(rd), 8'h3C);
        master_ack(1'b0);
        idle(HP);
        check("R8 released after nack", int'(sda_oe), 0);
        bus_stop();
        check("R8 read left regs", int'(div), 15'h4455);
        idle(10);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule